// File: doc/BRIEF.md
# Clock output bank controller

This block produces five banks of clock outputs, two identical outputs per bank, and a feedback pair made of a true output and its complement. All outputs are registered waveforms inside a single master clock domain. A free-running 3-bit phase counter is shared by all banks, so every bank stays phase-aligned. The fastest waveform toggles on every master edge and stands in for the nominal oscillator rate. Each bank, and the feedback pair, has its own 2-bit function select: pass-through, inversion, divide-by-2 or divide-by-4.

The outputs can be stopped in two ways. A synchronous stop request stops the banks only. An active-low power-down input stops the banks and the feedback pair. A stop takes effect only once the generated waveform already sits at the stop level, so no pulse is cut short. The stop level is the opposite of the active edge chosen by the edge-polarity input. The output mode picks whether a stopped output is held at that level or released to high impedance. High impedance is shown by a per-bank enable flag, plus one flag for the feedback pair. Stopped outputs resume only at the end of the slowest divide period.

A bypass input replaces every generated level with the selected reference input, with no register in the path. The enable flags are not changed by bypass.

Top module: `clkbank_ctrl`

## Requirements
- R1: While `rst_n` is low, the phase counter is 0, every `bank_q` bit and `fb_q` are 0, `fb_qn` is 1, and every enable flag is 1.
- R2: A running bank, after the k-th rising edge since reset release (k≥1), shows the value f(c) with c=(k-1) mod 8. The function code selects f: 00 gives bit 0 of c, 01 gives its inverse, 10 gives bit 1 of c, and 11 gives bit 2 of c. Bank b takes its code from `fn_sel[2b+1:2b]`, and both outputs of a bank are equal.
- R3: The running feedback output follows the same rule using `fb_fn`, and `fb_qn` is always the inverse of `fb_q`.
- R4: While a stop applies, an output keeps its generated waveform until the edge at which that waveform equals the stop level. From that edge on, the output is stopped.
- R5: The stop level is the inverse of `edge_pos`: high for `edge_pos`=0 and low for `edge_pos`=1. While stopped with `hold_mode`=1, the output shows that level and its enable is 1.
- R6: While stopped, the enable flag is registered from `hold_mode`, so `hold_mode`=0 gives enable 0 (high impedance) one edge later.
- R7: `pd_n`=0 stops the banks and `fb_q` under the R4–R6 rules. `fb_qn` then sits at the opposite level.
- R8: `stop_req` has no effect on the feedback pair or on `fb_oe`.
- R9: A stopped output with no stop applied resumes at the edge where the phase counter is 7. At that edge it loads f(7), and its enable is set to 1.
- R10: With `bypass`=1, every `bank_q` bit and `fb_q` equal the selected reference at once, and `fb_qn` is its inverse. The enable flags are unaffected.
- R11: `ref_pick`=0 selects `ref_in[0]`, and `ref_pick`=1 selects `ref_in[1]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 2 | Reference inputs used in bypass |
| ref_pick | input | 1 | Reference select |
| fn_sel | input | 2*NB | Function code per bank |
| fb_fn | input | 2 | Function code of the feedback pair |
| stop_req | input | 1 | Synchronous stop for the banks, active high |
| pd_n | input | 1 | Power-down, active low |
| hold_mode | input | 1 | 1: hold the stop level, 0: high impedance |
| edge_pos | input | 1 | Active edge; stop level is its inverse |
| bypass | input | 1 | Route the reference to all outputs |
| bank_q | output | NB*OPB | Bank outputs, bank b at bits [b*OPB +: OPB] |
| bank_oe | output | NB | Per-bank output enable |
| fb_q | output | 1 | True feedback output |
| fb_qn | output | 1 | Complement feedback output |
| fb_oe | output | 1 | Feedback output enable |

## Verification
Some rules are checked by the assertions on every cycle. Once a bank stop or a power-down has been held for six edges with a steady polarity, the outputs must sit at the stop level, or be disabled when high impedance is selected. An enable can only be low if the output mode was high impedance one edge earlier. After nine edges with power-down inactive, the feedback enable must be high. Other behaviour can only be shown by the bench scenarios against its own cycle-by-cycle model:
- exact waveform phases for every function code;
- the edge at which a stop takes effect;
- release on the counter boundary;
- reference selection in bypass.

// File: rtl/clkbank_ctrl.sv
module clkbank_ctrl #(
  parameter int NB  = 5,
  parameter int OPB = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      ref_in,
  input  logic            ref_pick,
  input  logic [2*NB-1:0] fn_sel,
  input  logic [1:0]      fb_fn,
  input  logic            stop_req,
  input  logic            pd_n,
  input  logic            hold_mode,
  input  logic            edge_pos,
  input  logic            bypass,
  output logic [NB*OPB-1:0] bank_q,
  output logic [NB-1:0]   bank_oe,
  output logic            fb_q,
  output logic            fb_qn,
  output logic            fb_oe
);
  localparam int CW = 3;

  logic [CW-1:0] phase;
  logic ref_v, lvl, bank_halt;

  function automatic logic wave(input logic [1:0] fn, input logic [CW-1:0] c);
    case (fn)
      2'b00:   return c[0];
      2'b01:   return ~c[0];
      2'b10:   return c[1];
      default: return c[2];
    endcase
  endfunction

  assign ref_v     = ref_in[ref_pick];
  assign lvl       = ~edge_pos;
  assign bank_halt = stop_req | ~pd_n;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) phase <= '0;
    else        phase <= phase + 1'b1;

  for (genvar u = 0; u <= NB; u++) begin : g_unit
    logic [1:0] fn;
    logic req, w, q, st, oe;

    if (u < NB) begin : g_bank
      assign fn  = fn_sel[2*u +: 2];
      assign req = bank_halt;
      assign bank_q[u*OPB +: OPB] = bypass ? {OPB{ref_v}} : {OPB{q}};
      assign bank_oe[u] = oe;
    end else begin : g_fb
      assign fn    = fb_fn;
      assign req   = ~pd_n;
      assign fb_q  = bypass ? ref_v : q;
      assign fb_qn = ~fb_q;
      assign fb_oe = oe;
    end

    assign w = wave(fn, phase);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= 1'b0; st <= 1'b0; oe <= 1'b1;
      end else if (!st) begin
        if (req && w == lvl) begin
          st <= 1'b1; q <= lvl; oe <= hold_mode;
        end else begin
          q <= w;
        end
      end else if (!req && phase == {CW{1'b1}}) begin
        st <= 1'b0; q <= w; oe <= 1'b1;
      end else begin
        q <= lvl; oe <= hold_mode;
      end
    end
  end
endmodule

module clkbank_ctrl_chk #(
  parameter int NB  = 5,
  parameter int OPB = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stop_req,
  input logic              pd_n,
  input logic              hold_mode,
  input logic              edge_pos,
  input logic              bypass,
  input logic [NB*OPB-1:0] bank_q,
  input logic [NB-1:0]     bank_oe,
  input logic              fb_q,
  input logic              fb_qn,
  input logic              fb_oe
);
  logic [3:0] halt_cnt, pd_cnt, up_cnt;
  logic prev_ep;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      halt_cnt <= '0; pd_cnt <= '0; up_cnt <= '0; prev_ep <= 1'b0;
    end else begin
      prev_ep  <= edge_pos;
      halt_cnt <= ((stop_req || !pd_n) && edge_pos == prev_ep) ? ((halt_cnt == 4'hF) ? halt_cnt : halt_cnt + 1'b1) : '0;
      pd_cnt   <= (!pd_n && edge_pos == prev_ep) ? ((pd_cnt == 4'hF) ? pd_cnt : pd_cnt + 1'b1) : '0;
      up_cnt   <= pd_n ? ((up_cnt == 4'hF) ? up_cnt : up_cnt + 1'b1) : '0;
    end

  p_hold_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_cnt >= 6 && edge_pos == prev_ep && !bypass) |-> bank_q == {(NB*OPB){~edge_pos}});

  p_hiz_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_cnt >= 6 && !hold_mode && !$past(hold_mode)) |-> bank_oe == '0);

  p_oe_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(&bank_oe) || !fb_oe |-> !$past(hold_mode));

  p_pd_fb_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_cnt >= 6 && edge_pos == prev_ep && !bypass && hold_mode && $past(hold_mode))
      |-> (fb_q == ~edge_pos && fb_qn == edge_pos && fb_oe));

  p_fb_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    up_cnt >= 9 |-> fb_oe);
endmodule

bind clkbank_ctrl clkbank_ctrl_chk #(.NB(NB), .OPB(OPB)) u_chk (
  .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .pd_n(pd_n),
  .hold_mode(hold_mode), .edge_pos(edge_pos), .bypass(bypass),
  .bank_q(bank_q), .bank_oe(bank_oe), .fb_q(fb_q), .fb_qn(fb_qn), .fb_oe(fb_oe)
);

// File: tb/clkbank_ctrl_bench.sv
`timescale 1ns/1ps
module clkbank_ctrl_bench;
  localparam int NB = 5, OPB = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] ref_in = 2'b00, fb_fn = 2'b00;
  logic ref_pick = 1'b0, stop_req = 1'b0, pd_n = 1'b1, hold_mode = 1'b1;
  logic edge_pos = 1'b1, bypass = 1'b0;
  logic [2*NB-1:0] fn_sel = '0;
  logic [NB*OPB-1:0] bank_q;
  logic [NB-1:0] bank_oe;
  logic fb_q, fb_qn, fb_oe;

  int total = 0, bad = 0, cycles = 0;
  string tag_b = "R1", tag_f = "R1";

  always #2 clk = ~clk;

  clkbank_ctrl #(.NB(NB), .OPB(OPB)) u_clkbank_ctrl (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .ref_pick(ref_pick),
    .fn_sel(fn_sel), .fb_fn(fb_fn), .stop_req(stop_req), .pd_n(pd_n),
    .hold_mode(hold_mode), .edge_pos(edge_pos), .bypass(bypass),
    .bank_q(bank_q), .bank_oe(bank_oe), .fb_q(fb_q), .fb_qn(fb_qn), .fb_oe(fb_oe));

  // reference model built from the requirements
  int mc;
  bit mq[NB+1], mst[NB+1], moe[NB+1];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mc = 0;
      for (int u = 0; u <= NB; u++) begin mq[u] = 0; mst[u] = 0; moe[u] = 1; end
    end else begin
      for (int u = 0; u <= NB; u++) begin
        int fn; bit req, w, lv;
        fn  = (u < NB) ? int'(fn_sel[2*u +: 2]) : int'(fb_fn);
        req = (u < NB) ? (stop_req || !pd_n) : !pd_n;
        case (fn)
          0: w = bit'(mc % 2);
          1: w = bit'(1 - mc % 2);
          2: w = bit'((mc / 2) % 2);
          default: w = bit'(mc / 4);
        endcase
        lv = !edge_pos;
        if (!mst[u]) begin
          if (req && w == lv) begin mst[u] = 1; mq[u] = lv; moe[u] = hold_mode; end
          else mq[u] = w;
        end else if (!req && mc == 7) begin
          mst[u] = 0; mq[u] = w; moe[u] = 1;
        end else begin
          mq[u] = lv; moe[u] = hold_mode;
        end
      end
      mc = (mc + 1) % 8;
    end
  end

  task automatic check(input string tag, input int act, input int exp, input string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit rv;
    rv = ref_in[ref_pick];
    for (int b = 0; b < NB; b++) begin
      check(tag_b, int'(bank_q[b*OPB +: OPB]), bypass ? (rv ? 3 : 0) : (mq[b] ? 3 : 0), "bank_q");
      check(tag_b, int'(bank_oe[b]), int'(moe[b]), "bank_oe");
    end
    check(tag_f, int'(fb_q), bypass ? int'(rv) : int'(mq[NB]), "fb_q");
    check("R3", int'(fb_qn), int'(!fb_q), "fb_qn");
    check(tag_f, int'(fb_oe), int'(moe[NB]), "fb_oe");
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
      compare();
      ref_in = ref_in + 2'd1 + 2'(i % 2);
    end
  endtask

  task automatic set_fn(input int k);
    for (int b = 0; b < NB; b++) fn_sel[2*b +: 2] = 2'((b + k) % 4);
    fb_fn = 2'(k);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, 20000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    tick(3);
    rst_n = 1'b1;
    // R2 / R3: every function code on every bank and on feedback
    tag_b = "R2"; tag_f = "R3";
    for (int k = 0; k < 4; k++) begin set_fn(k); tick(12); end
    // R4, R5, R6, R8, R9: bank stop in both modes and polarities
    for (int k = 0; k < 4; k++)
      for (int hm = 0; hm < 2; hm++)
        for (int ep = 0; ep < 2; ep++) begin
          set_fn(k); hold_mode = hm[0]; edge_pos = ep[0];
          stop_req = 1'b1; tag_b = "R4"; tag_f = "R8"; tick(4);
          tag_b = hm ? "R5" : "R6"; tick(8);
          stop_req = 1'b0; tag_b = "R9"; tick(12);
        end
    // R7, R9: power-down including feedback
    for (int hm = 0; hm < 2; hm++)
      for (int ep = 0; ep < 2; ep++) begin
        set_fn(hm * 2 + ep); hold_mode = hm[0]; edge_pos = ep[0];
        pd_n = 1'b0; tag_b = "R7"; tag_f = "R7"; tick(12);
        pd_n = 1'b1; tag_b = "R9"; tag_f = "R9"; tick(12);
      end
    // R10, R11: bypass with each reference, running and while tri-stated
    for (int rp = 0; rp < 2; rp++) begin
      ref_pick = rp[0]; bypass = 1'b1;
      tag_b = rp ? "R11" : "R10"; tag_f = tag_b; tick(10);
      hold_mode = 1'b0; stop_req = 1'b1; pd_n = 1'b0; tick(10);
      stop_req = 1'b0; pd_n = 1'b1; hold_mode = 1'b1; tick(10);
      bypass = 1'b0; tick(4);
    end
    // R1 again: reset in the middle of activity
    rst_n = 1'b0; tag_b = "R1"; tag_f = "R1"; tick(2);
    rst_n = 1'b1; tag_b = "R2"; tag_f = "R3"; tick(8);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule